// File: doc/BRIEF.md
# Snooping Cache Coherence Controller

This block sits beside one direct-mapped cache and keeps it coherent with its peers on a shared snooping bus. Each line is in one of three states: invalid, shared (clean and read-only) or exclusive (dirty and writable). The protocol is write-invalidate. A cache that wants to write first takes ownership with a write-miss transaction, and that transaction removes every other copy of the block. The processor side takes one read or write request at a time and returns a response that carries a hit flag and the line's data.

On the bus side the controller raises a request, waits for a grant and drives one single-cycle transaction for each grant: read miss, write miss or write-back. In the same cycles it watches the transactions that other caches drive. When a snooped miss hits a dirty line here, the controller drives the block onto the bus and raises a supply flag. The supply flag tells memory to take that block in place of its own copy, and the requester fills from it. Arbitration between caches and the memory itself are outside the block.

Processor handshake: a request is taken on a clock edge where `cpu_req_valid` and `cpu_req_ready` are both high. The requester holds the request fields stable while valid is high and ready is low. `cpu_req_ready` is low whenever a bus transaction is pending, and also in any cycle where a snooped miss hits a valid line. The response is a single-cycle pulse on `cpu_rsp_valid`, and it cannot be back-pressured. An address splits into a line index (its low `INDEX_W` bits) and a tag (the remaining bits). A line holds one data word.

Top module: `snoop_cache_ctl`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, and `bus_req` and `cpu_rsp_valid` are low.
- R2: A read that misses drives exactly one read-miss transaction (`bus_cmd` = 1). The line is then shared, and the response has hit = 0 and the filled data. That response comes in the cycle after the granted transaction.
- R3: A write to a line that is invalid or shared drives exactly one write-miss transaction (`bus_cmd` = 2). The line then becomes exclusive and holds the written word, and the response has hit = 0.
- R4: When a miss replaces an exclusive line that has a different tag, the controller first drives a write-back (`bus_cmd` = 3) with the old address and data, then drives the miss. A shared victim is dropped with no write-back.
- R5: A read hit (shared or exclusive) or a write hit (exclusive) responds in the cycle after acceptance with hit = 1 and drives no bus transaction.
- R6: A snooped read miss to a line held exclusive raises `snp_supply` with the block on `snp_data`, and the line drops to shared. A later local write to that line is then a miss.
- R7: A snooped write miss to a line held shared invalidates it, so a later local read misses and fetches the writer's value.
- R8: A snooped write miss to a line held exclusive raises `snp_supply` with the block and then invalidates the line.
- R9: A snooped read miss to a line held shared leaves the line shared and does not raise `snp_supply`.
- R10: A bus command other than 0 is driven only while both `bus_req` and `bus_gnt` are high. `bus_req` stays high until the transaction is granted, and `cpu_req_ready` stays low while a transaction is pending.
- R11: In a cycle where a snooped miss hits a valid line, the snoop takes priority and `cpu_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can accept a request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Response was served without the bus |
| cpu_rsp_rdata | output | DATA_W | Line data after the access |
| bus_req | output | 1 | Bus wanted for a pending transaction |
| bus_gnt | input | 1 | Grant for this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the driven transaction |
| bus_wdata | output | DATA_W | Block data for a write-back |
| bus_fill_data | input | DATA_W | Fill data for this cache's miss (supplied block or memory) |
| snp_valid | input | 1 | Another cache drives a transaction |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the block; memory access aborted |
| snp_data | output | DATA_W | Supplied block |

## Verification
An exclusive line wrongly left valid or a shared line wrongly kept after a peer's write shows up at the next local access to that line. That access comes back with hit = 1 and stale data, where a miss with the peer's value was due. A dirty line that was not tracked correctly appears as a missing or stray `snp_supply` in the very cycle a peer's miss is on the bus. It also appears later as stale memory data returned to another cache. A victim that is never written back is seen when a peer reads that address after the replacement and gets memory's old word.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_NONE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WBACK  = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WB   = 2'd1,
    CP_MISS = 2'd2
  } cpu_fsm_t;
endpackage

// File: rtl/ccc_line_store.sv
module ccc_line_store
  import ccc_pkg::*;
#(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] cpu_idx,
  output line_st_t           cpu_st,
  output logic [TAG_W-1:0]   cpu_tag,
  output logic [DATA_W-1:0]  cpu_data,
  input  logic [INDEX_W-1:0] snp_idx,
  output line_st_t           snp_st,
  output logic [TAG_W-1:0]   snp_tag,
  output logic [DATA_W-1:0]  snp_data,
  input  logic               cw_en,
  input  logic [INDEX_W-1:0] cw_idx,
  input  line_st_t           cw_st,
  input  logic [TAG_W-1:0]   cw_tag,
  input  logic [DATA_W-1:0]  cw_data,
  input  logic               sw_en,
  input  logic [INDEX_W-1:0] sw_idx,
  input  line_st_t           sw_st
);
  localparam int LINES = 1 << INDEX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // State bits need reset; the snoop update wins if both target one line.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[g] <= LN_INV;
      end else if (sw_en && sw_idx == INDEX_W'(g)) begin
        st_q[g] <= sw_st;
      end else if (cw_en && cw_idx == INDEX_W'(g)) begin
        st_q[g] <= cw_st;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cw_en) begin
      tag_q[cw_idx]  <= cw_tag;
      data_q[cw_idx] <= cw_data;
    end
  end

  assign cpu_st   = st_q[cpu_idx];
  assign cpu_tag  = tag_q[cpu_idx];
  assign cpu_data = data_q[cpu_idx];
  assign snp_st   = st_q[snp_idx];
  assign snp_tag  = tag_q[snp_idx];
  assign snp_data = data_q[snp_idx];
endmodule

// File: rtl/ccc_snoop_resp.sv
module ccc_snoop_resp
  import ccc_pkg::*;
#(
  parameter int TAG_W  = 10,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  bus_cmd_t          snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag_in,
  input  line_st_t          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              snp_hit,
  output logic              sw_en,
  output line_st_t          sw_st,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data
);
  logic is_miss_cmd;

  always_comb begin
    is_miss_cmd = (snp_cmd == BC_RDMISS) || (snp_cmd == BC_WRMISS);
    snp_hit     = snp_valid && is_miss_cmd && (line_st != LN_INV) && (line_tag == snp_tag_in);
    sw_en       = 1'b0;
    sw_st       = line_st;
    supply      = 1'b0;
    supply_data = line_data;
    if (snp_hit) begin
      if (snp_cmd == BC_RDMISS) begin
        if (line_st == LN_EXC) begin
          supply = 1'b1;
          sw_en  = 1'b1;
          sw_st  = LN_SHR;
        end
      end else begin
        supply = (line_st == LN_EXC);
        sw_en  = 1'b1;
        sw_st  = LN_INV;
      end
    end
  end
endmodule

// File: rtl/ccc_cpu_ctrl.sv
module ccc_cpu_ctrl
  import ccc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_we,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic                      snp_hit,
  output logic                      req_ready,
  output logic [INDEX_W-1:0]        look_idx,
  input  line_st_t                  look_st,
  input  logic [ADDR_W-INDEX_W-1:0] look_tag,
  input  logic [DATA_W-1:0]         look_data,
  output logic                      cw_en,
  output line_st_t                  cw_st,
  output logic [ADDR_W-INDEX_W-1:0] cw_tag,
  output logic [DATA_W-1:0]         cw_data,
  output logic                      bus_req,
  input  logic                      bus_gnt,
  output bus_cmd_t                  bus_cmd,
  output logic [ADDR_W-1:0]         bus_addr,
  output logic [DATA_W-1:0]         bus_wdata,
  input  logic [DATA_W-1:0]         bus_fill,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [DATA_W-1:0]         rsp_rdata
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  cpu_fsm_t          fsm_q;
  logic              pend_we_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_eq, accept, hit_now, victim_dirty;
  logic              wb_phase, granted, fill_done;

  always_comb begin
    cur_addr     = (fsm_q == CP_IDLE) ? req_addr : pend_addr_q;
    look_idx     = cur_addr[INDEX_W-1:0];
    cur_tag      = cur_addr[ADDR_W-1:INDEX_W];
    tag_eq       = (look_tag == cur_tag);
    req_ready    = (fsm_q == CP_IDLE) && !snp_hit;
    accept       = req_valid && req_ready;
    hit_now      = accept && tag_eq &&
                   (req_we ? (look_st == LN_EXC) : (look_st != LN_INV));
    victim_dirty = (look_st == LN_EXC) && !tag_eq;
    bus_req      = (fsm_q != CP_IDLE);
    // A victim taken away by a snoop while waiting skips its write-back.
    wb_phase     = (fsm_q == CP_WB) && victim_dirty;
    granted      = bus_req && bus_gnt;
    fill_done    = granted && !wb_phase;
  end

  always_comb begin
    bus_cmd   = BC_NONE;
    bus_addr  = '0;
    bus_wdata = '0;
    if (granted) begin
      if (wb_phase) begin
        bus_cmd   = BC_WBACK;
        bus_addr  = {look_tag, look_idx};
        bus_wdata = look_data;
      end else begin
        bus_cmd   = pend_we_q ? BC_WRMISS : BC_RDMISS;
        bus_addr  = pend_addr_q;
        bus_wdata = pend_we_q ? pend_wdata_q : '0;
      end
    end
  end

  always_comb begin
    cw_en   = 1'b0;
    cw_st   = LN_EXC;
    cw_tag  = cur_tag;
    cw_data = req_wdata;
    if (hit_now && req_we) begin
      cw_en = 1'b1;
    end else if (fill_done) begin
      cw_en   = 1'b1;
      cw_st   = pend_we_q ? LN_EXC : LN_SHR;
      cw_data = pend_we_q ? pend_wdata_q : bus_fill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q        <= CP_IDLE;
      pend_we_q    <= 1'b0;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= hit_now || fill_done;
      if (hit_now) begin
        rsp_hit   <= 1'b1;
        rsp_rdata <= req_we ? req_wdata : look_data;
      end else if (fill_done) begin
        rsp_hit   <= 1'b0;
        rsp_rdata <= pend_we_q ? pend_wdata_q : bus_fill;
      end
      unique case (fsm_q)
        CP_IDLE: begin
          if (accept && !hit_now) begin
            pend_we_q    <= req_we;
            pend_addr_q  <= req_addr;
            pend_wdata_q <= req_wdata;
            fsm_q        <= victim_dirty ? CP_WB : CP_MISS;
          end
        end
        CP_WB: begin
          if (granted) fsm_q <= wb_phase ? CP_MISS : CP_IDLE;
        end
        CP_MISS: begin
          if (granted) fsm_q <= CP_IDLE;
        end
        default: fsm_q <= CP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_cache_ctl.sv
module snoop_cache_ctl
  import ccc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic              cpu_rsp_hit,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] look_idx;
  line_st_t           look_st, sl_st, cw_st, sw_st;
  logic [TAG_W-1:0]   look_tag, sl_tag, cw_tag;
  logic [DATA_W-1:0]  look_data, sl_data, cw_data;
  logic               cw_en, sw_en, snp_hit;
  bus_cmd_t           cmd_e;

  ccc_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_idx  (look_idx),
    .cpu_st   (look_st),
    .cpu_tag  (look_tag),
    .cpu_data (look_data),
    .snp_idx  (snp_addr[INDEX_W-1:0]),
    .snp_st   (sl_st),
    .snp_tag  (sl_tag),
    .snp_data (sl_data),
    .cw_en    (cw_en),
    .cw_idx   (look_idx),
    .cw_st    (cw_st),
    .cw_tag   (cw_tag),
    .cw_data  (cw_data),
    .sw_en    (sw_en),
    .sw_idx   (snp_addr[INDEX_W-1:0]),
    .sw_st    (sw_st)
  );

  ccc_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid   (snp_valid),
    .snp_cmd     (bus_cmd_t'(snp_cmd)),
    .snp_tag_in  (snp_addr[ADDR_W-1:INDEX_W]),
    .line_st     (sl_st),
    .line_tag    (sl_tag),
    .line_data   (sl_data),
    .snp_hit     (snp_hit),
    .sw_en       (sw_en),
    .sw_st       (sw_st),
    .supply      (snp_supply),
    .supply_data (snp_data)
  );

  ccc_cpu_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DATA_W(DATA_W)) u_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_req_valid),
    .req_we    (cpu_req_we),
    .req_addr  (cpu_req_addr),
    .req_wdata (cpu_req_wdata),
    .snp_hit   (snp_hit),
    .req_ready (cpu_req_ready),
    .look_idx  (look_idx),
    .look_st   (look_st),
    .look_tag  (look_tag),
    .look_data (look_data),
    .cw_en     (cw_en),
    .cw_st     (cw_st),
    .cw_tag    (cw_tag),
    .cw_data   (cw_data),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (cmd_e),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_fill  (bus_fill_data),
    .rsp_valid (cpu_rsp_valid),
    .rsp_hit   (cpu_rsp_hit),
    .rsp_rdata (cpu_rsp_rdata)
  );

  assign bus_cmd = cmd_e;
endmodule

// File: rtl/ccc_checker.sv
module ccc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req_ready,
  input logic       cpu_rsp_valid,
  input logic       cpu_rsp_hit,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_supply
);
  AST_CMD_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_req && bus_gnt)); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req); // R10
  AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_req_ready); // R10
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> !cpu_req_ready); // R11
  AST_SUPPLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))); // R6
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && cpu_rsp_hit) |-> !$past(bus_req)); // R5
  AST_MISS_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_hit) |-> $past(bus_gnt && (bus_cmd == 2'd1 || bus_cmd == 2'd2))); // R2
  AST_WB_THEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd3) |=> bus_req); // R4
endmodule

bind snoop_cache_ctl ccc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_req_ready (cpu_req_ready),
  .cpu_rsp_valid (cpu_rsp_valid),
  .cpu_rsp_hit   (cpu_rsp_hit),
  .bus_req       (bus_req),
  .bus_gnt       (bus_gnt),
  .bus_cmd       (bus_cmd),
  .snp_valid     (snp_valid),
  .snp_cmd       (snp_cmd),
  .snp_supply    (snp_supply)
);

// File: tb/snoop_cache_ctl_tb.sv
module snoop_cache_ctl_tb;
  localparam int AW = 8;
  localparam int IW = 2;
  localparam int DW = 16;
  localparam int NV = 14;

  function automatic logic [DW-1:0] iv(input logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  typedef struct packed {
    logic          sel;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          hit;
    logic [DW-1:0] rdata;
    logic [1:0]    nrd;
    logic [1:0]    nwr;
    logic [1:0]    nwb;
    logic [1:0]    nsup;
  } vec_t;

  // sel 0 = cache A (u_dut of slot 0), 1 = cache B
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h10, 16'h0000, 1'b0, iv(8'h10), 2'd1, 2'd0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 8'h10, 16'h0000, 1'b0, iv(8'h10), 2'd1, 2'd0, 2'd0, 2'd0},
    '{1'b0, 1'b0, 8'h10, 16'h0000, 1'b1, iv(8'h10), 2'd0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'h10, 16'hBEEF, 1'b0, 16'hBEEF,  2'd0, 2'd1, 2'd0, 2'd0},
    '{1'b1, 1'b0, 8'h10, 16'h0000, 1'b0, 16'hBEEF,  2'd1, 2'd0, 2'd0, 2'd1},
    '{1'b0, 1'b0, 8'h10, 16'h0000, 1'b1, 16'hBEEF,  2'd0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'h10, 16'h1234, 1'b0, 16'h1234,  2'd0, 2'd1, 2'd0, 2'd0},
    '{1'b0, 1'b1, 8'h10, 16'h5678, 1'b1, 16'h5678,  2'd0, 2'd0, 2'd0, 2'd0},
    '{1'b1, 1'b1, 8'h10, 16'h7777, 1'b0, 16'h7777,  2'd0, 2'd1, 2'd0, 2'd1},
    '{1'b0, 1'b0, 8'h10, 16'h0000, 1'b0, 16'h7777,  2'd1, 2'd0, 2'd0, 2'd1},
    '{1'b0, 1'b1, 8'h14, 16'h0AAA, 1'b0, 16'h0AAA,  2'd0, 2'd1, 2'd0, 2'd0},
    '{1'b0, 1'b0, 8'h18, 16'h0000, 1'b0, iv(8'h18), 2'd1, 2'd0, 2'd1, 2'd0},
    '{1'b1, 1'b0, 8'h14, 16'h0000, 1'b0, 16'h0AAA,  2'd1, 2'd0, 2'd0, 2'd0},
    '{1'b1, 1'b0, 8'h10, 16'h0000, 1'b0, 16'h7777,  2'd1, 2'd0, 2'd0, 2'd0}
  };

  function automatic string vreq(input int i);
    case (i)
      0:       return "R2";
      1, 2:    return "R9";
      3, 10:   return "R3";
      4:       return "R7";
      5, 6:    return "R6";
      7:       return "R5";
      8, 9:    return "R8";
      default: return "R4";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          rq_v  [2];
  logic          rq_we [2];
  logic [AW-1:0] rq_a  [2];
  logic [DW-1:0] rq_d  [2];
  logic          rdy   [2];
  logic          rv    [2];
  logic          rh    [2];
  logic [DW-1:0] rd    [2];
  logic          breq  [2];
  logic          bgnt  [2];
  logic [1:0]    bcmd  [2];
  logic [AW-1:0] badr  [2];
  logic [DW-1:0] bwd   [2];
  logic [DW-1:0] bfill [2];
  logic          svld  [2];
  logic [1:0]    scmd  [2];
  logic [AW-1:0] sadr  [2];
  logic          sup   [2];
  logic [DW-1:0] sdat  [2];
  logic [DW-1:0] mem   [256];

  for (genvar k = 0; k < 2; k++) begin : g_cache
    snoop_cache_ctl #(.ADDR_W(AW), .INDEX_W(IW), .DATA_W(DW)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (rq_v[k]),
      .cpu_req_ready (rdy[k]),
      .cpu_req_we    (rq_we[k]),
      .cpu_req_addr  (rq_a[k]),
      .cpu_req_wdata (rq_d[k]),
      .cpu_rsp_valid (rv[k]),
      .cpu_rsp_hit   (rh[k]),
      .cpu_rsp_rdata (rd[k]),
      .bus_req       (breq[k]),
      .bus_gnt       (bgnt[k]),
      .bus_cmd       (bcmd[k]),
      .bus_addr      (badr[k]),
      .bus_wdata     (bwd[k]),
      .bus_fill_data (bfill[k]),
      .snp_valid     (svld[k]),
      .snp_cmd       (scmd[k]),
      .snp_addr      (sadr[k]),
      .snp_supply    (sup[k]),
      .snp_data      (sdat[k])
    );
  end

  // Fixed-priority arbiter and bus fabric
  always_comb begin
    bgnt[0]  = breq[0];
    bgnt[1]  = breq[1] && !breq[0];
    svld[0]  = (bcmd[1] != 2'd0);
    scmd[0]  = bcmd[1];
    sadr[0]  = badr[1];
    svld[1]  = (bcmd[0] != 2'd0);
    scmd[1]  = bcmd[0];
    sadr[1]  = badr[0];
    bfill[0] = sup[1] ? sdat[1] : mem[badr[0]];
    bfill[1] = sup[0] ? sdat[0] : mem[badr[1]];
  end

  // Memory model: takes write-backs and supplied blocks
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= iv(AW'(i));
    end else begin
      if (bcmd[0] == 2'd3) mem[badr[0]] <= bwd[0];
      if (bcmd[1] == 2'd3) mem[badr[1]] <= bwd[1];
      if (sup[0]) mem[badr[1]] <= sdat[0];
      if (sup[1]) mem[badr[0]] <= sdat[1];
    end
  end

  int n_rd = 0, n_wr = 0, n_wb = 0, n_sup = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      case (bcmd[0] | bcmd[1])
        2'd1: n_rd++;
        2'd2: n_wr++;
        2'd3: n_wb++;
        default: ;
      endcase
      if (sup[0] || sup[1]) n_sup++;
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic finished = 1'b0;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_req(input int s, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic hit, output logic [DW-1:0] data, output int lat);
    int guard = 0;
    @(negedge clk);
    rq_v[s] = 1'b1; rq_we[s] = we; rq_a[s] = a; rq_d[s] = d;
    #1;
    while (!rdy[s] && guard < 200) begin
      @(negedge clk); #1; guard++;
    end
    @(posedge clk);
    #1 rq_v[s] = 1'b0;
    lat = 0; hit = 1'bx; data = 'x;
    while (lat < 200) begin
      @(negedge clk);
      lat++;
      if (rv[s]) begin
        hit = rh[s]; data = rd[s];
        break;
      end
    end
  endtask

  initial begin
    logic          h;
    logic [DW-1:0] dv;
    int            lat;
    int            c_rd, c_wr, c_wb, c_sup;
    for (int k = 0; k < 2; k++) begin
      rq_v[k] = 1'b0; rq_we[k] = 1'b0; rq_a[k] = '0; rq_d[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R1", "ready in reset", 32'(rdy[k]), 32'd1);
      chk("R1", "bus_req in reset", 32'(breq[k]), 32'd0);
      chk("R1", "rsp_valid in reset", 32'(rv[k]), 32'd0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      c_rd = n_rd; c_wr = n_wr; c_wb = n_wb; c_sup = n_sup;
      run_req(int'(VEC[i].sel), VEC[i].we, VEC[i].addr, VEC[i].wdata, h, dv, lat);
      chk(vreq(i), $sformatf("vec %0d hit", i), 32'(h), 32'(VEC[i].hit));
      chk(vreq(i), $sformatf("vec %0d rdata", i), 32'(dv), 32'(VEC[i].rdata));
      chk(vreq(i), $sformatf("vec %0d read-miss count", i), 32'(n_rd - c_rd), 32'(VEC[i].nrd));
      chk(vreq(i), $sformatf("vec %0d write-miss count", i), 32'(n_wr - c_wr), 32'(VEC[i].nwr));
      chk(vreq(i), $sformatf("vec %0d write-back count", i), 32'(n_wb - c_wb), 32'(VEC[i].nwb));
      chk(vreq(i), $sformatf("vec %0d supply count", i), 32'(n_sup - c_sup), 32'(VEC[i].nsup));
      if (VEC[i].hit) chk("R5", $sformatf("vec %0d hit latency", i), 32'(lat), 32'd1);
    end

    // Directed: A write-misses 0x10 while B asks to read its shared copy.
    // State now: A idx0 holds 0x18 shared, B idx0 holds 0x10 shared.
    @(negedge clk);
    rq_v[0] = 1'b1; rq_we[0] = 1'b1; rq_a[0] = 8'h10; rq_d[0] = 16'h4242;
    #1 chk("R1", "A ready before directed write", 32'(rdy[0]), 32'd1);
    @(posedge clk);
    #1 rq_v[0] = 1'b0;
    @(negedge clk);
    chk("R3", "write-miss on bus", 32'(bcmd[0]), 32'd2);
    rq_v[1] = 1'b1; rq_we[1] = 1'b0; rq_a[1] = 8'h10; rq_d[1] = '0;
    #1 chk("R11", "B ready during snoop hit", 32'(rdy[1]), 32'd0);
    @(negedge clk);
    chk("R3", "A directed rsp valid", 32'(rv[0]), 32'd1);
    chk("R3", "A directed rsp hit", 32'(rh[0]), 32'd0);
    chk("R3", "A directed rsp data", 32'(rd[0]), 32'h4242);
    #1 chk("R11", "B ready after snoop", 32'(rdy[1]), 32'd1);
    @(posedge clk);
    #1 rq_v[1] = 1'b0;
    @(negedge clk);
    chk("R10", "B stalled while miss pending", 32'(rdy[1]), 32'd0);
    chk("R7", "B was invalidated, read-miss on bus", 32'(bcmd[1]), 32'd1);
    chk("R6", "A supplies dirty block", 32'(sup[0]), 32'd1);
    chk("R6", "A supplied data", 32'(sdat[0]), 32'h4242);
    @(negedge clk);
    chk("R7", "B rsp valid", 32'(rv[1]), 32'd1);
    chk("R7", "B rsp hit", 32'(rh[1]), 32'd0);
    chk("R7", "B rsp data", 32'(rd[1]), 32'h4242);

    // A dropped to shared: its next write must be a miss.
    c_wr = n_wr;
    run_req(0, 1'b1, 8'h10, 16'h9999, h, dv, lat);
    chk("R6", "A write after supply is miss", 32'(h), 32'd0);
    chk("R6", "A write-miss count", 32'(n_wr - c_wr), 32'd1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule